// File: doc/BRIEF.md
# I/O Page Table Translation Engine

This block turns a 32-bit device DMA address into a 36-bit physical address. It does this with one lookup in a single-level page table held in memory. A request carries the device address and a read/write flag. The engine reads the translation configuration at the moment it accepts the request. That configuration is a table base value and a 3-bit window-size code, where code `n` selects a window of 16 MiB << n that ends at the top of the 32-bit space. From these the engine forms the address of the table entry.

The engine fetches the entry through a valid/ready read-request channel and a separate read-response channel. It then decodes the entry and returns one response pulse. The pulse carries either the physical address and its permission, or a fault. When a fault occurs, the engine also sends a status word and the page-aligned device address to the register file, together with a one-cycle interrupt request.

Only one translation is in flight at a time. The register file owns the base register and its masking. Caching of entries and the data transfer itself sit outside this block.

Top module: `iopt_xlate_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, `req_ready` is 1 and `pte_rd_valid`, `rsp_valid`, `rsp_fault`, `flt_wr` and `irq_raise` are 0.
- R2: The entry address is formed as follows:
  - Start from `cfg_base` shifted left by 4.
  - Take the device address and clear every bit at or above bit 24+`cfg_range`.
  - Shift that window-relative address right by 10 and force its two low bits to 0.
  - Add the two values, modulo 2^36.
- R3: On success, `rsp_pa` is entry bits 31:8 placed at PA[35:12], concatenated with device address bits 11:0.
- R4: An entry whose bit 1 (valid) is 0 causes a fault, for both reads and writes.
- R5: A write to an entry whose bit 2 (writable) is 0 causes a fault. A read of such a valid entry succeeds.
- R6: `rsp_perm` is 2'b11 (read-write) when entry bit 2 is set and 2'b01 (read-only) when it is clear. On a fault, `rsp_perm` is 2'b00 and `rsp_pa` is 0.
- R7: On a fault, `flt_status` is 0xE0820000, with bit 18 (0x00040000) added for a read. `flt_addr` is the device address with bits 11:0 cleared. `irq_raise` pulses in the same cycle.
- R8: `flt_wr` and `rsp_fault` are each high exactly in the response cycle of a faulting translation, and never otherwise.
- R9: From acceptance until the response cycle, `req_ready` is 0. While `pte_rd_valid` waits for `pte_rd_ready`, it stays high and `pte_rd_addr` is held.
- R10: Changes on `cfg_base` and `cfg_range` after a request is accepted have no effect on that translation.
- R11: Entry bits 7 (cacheable) and 0 (write-as-zero) do not change `rsp_pa`, `rsp_perm` or the fault decision.
- R12: `rsp_valid` is a one-cycle pulse. It appears in the cycle after the entry word is taken on the read-response channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | 32 | Page table base value, sampled at request acceptance |
| cfg_range | input | 3 | Window size code, 16 MiB << code, sampled at acceptance |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Engine can accept a request |
| req_addr | input | 32 | Device address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| pte_rd_valid | output | 1 | Entry read request valid |
| pte_rd_ready | input | 1 | Memory accepts the entry read |
| pte_rd_addr | output | 36 | Physical address of the entry |
| pte_rsp_valid | input | 1 | Entry word returned |
| pte_rsp_data | input | 32 | Entry word, most significant byte stored first |
| rsp_valid | output | 1 | Translation result pulse |
| rsp_pa | output | 36 | Translated physical address |
| rsp_perm | output | 2 | 11 read-write, 01 read-only, 00 none |
| rsp_fault | output | 1 | Result is a fault |
| flt_wr | output | 1 | Fault record write strobe to the register file |
| flt_status | output | 32 | Fault status word |
| flt_addr | output | 32 | Page-aligned faulting device address |
| irq_raise | output | 1 | Interrupt request pulse on a fault |

## Verification
The assertions check the channel rules on every cycle:
- the read request holds while stalled;
- no second request is accepted while one is in flight;
- the result pulse lasts one cycle and follows an entry beat;
- the fault strobe, fault flag and interrupt stay aligned, and the fault status pattern and page alignment are correct;
- the permission code agrees with the fault flag.

The entry address arithmetic across all window sizes, the decode of entry bits into address and permission, and the sampling of the configuration at acceptance depend on data. Only the bench's behavioural model can show these, by predicting every output cycle by cycle against a memory model with varying stalls and latencies.

// File: rtl/iopt_pkg.sv
// Package: shared constants and types for the I/O page table translation engine.
// Assumes 4 KiB pages and a 32-bit entry with the page number in its top 24 bits.
package iopt_pkg;
    localparam int unsigned DVA_W       = 32;
    localparam int unsigned PA_W        = 36;
    localparam int unsigned PAGE_SH     = 12;
    localparam int unsigned RANGE_W     = 3;
    localparam int unsigned MIN_WIN_SH  = 24;
    localparam int unsigned PTE_W       = 32;
    localparam int unsigned PTE_PPN_LSB = 8;
    localparam int unsigned PTE_WR_BIT  = 2;
    localparam int unsigned PTE_VLD_BIT = 1;

    localparam logic [31:0] FLT_STAT_BASE = 32'hE082_0000;
    localparam logic [31:0] FLT_STAT_READ = 32'h0004_0000;

    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_RO   = 2'b01,
        PERM_RW   = 2'b11
    } perm_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2
    } xl_state_e;
endpackage

// File: rtl/iopt_addr_gen.sv
// Module: iopt_addr_gen
// Computes the physical address of the page table entry for one device address.
// The window ends at the top of the device space and spans 2^(MIN_WIN_SH+range)
// bytes; bits at or above that size are cleared before indexing. Each 4 KiB page
// owns one 4-byte entry. Purely combinational.
module iopt_addr_gen #(
    parameter int unsigned DVA_W      = iopt_pkg::DVA_W,
    parameter int unsigned PA_W       = iopt_pkg::PA_W,
    parameter int unsigned RANGE_W    = iopt_pkg::RANGE_W,
    parameter int unsigned MIN_WIN_SH = iopt_pkg::MIN_WIN_SH,
    parameter int unsigned PAGE_SH    = iopt_pkg::PAGE_SH
) (
    input  logic [DVA_W-1:0]   base_i,
    input  logic [RANGE_W-1:0] range_i,
    input  logic [DVA_W-1:0]   dva_i,
    output logic [PA_W-1:0]    ea_o
);
    localparam int unsigned BASE_SH = PA_W - DVA_W;
    localparam int unsigned IDX_SH  = PAGE_SH - 2;

    logic [DVA_W-1:0] win_keep;
    logic [DVA_W-1:0] rel_addr;
    logic [DVA_W-1:0] idx_off;

    // One keep bit per address bit: low bits always kept, upper bits by range code.
    for (genvar i = 0; i < DVA_W; i++) begin : g_keep
        if (i < MIN_WIN_SH) begin : g_fixed
            assign win_keep[i] = 1'b1;
        end else begin : g_sel
            assign win_keep[i] = (32'(range_i) > 32'(i - MIN_WIN_SH));
        end
    end

    // Window-relative offset, scaled to a word-aligned entry offset, added to base.
    always_comb begin
        rel_addr = dva_i & win_keep;
        idx_off  = (rel_addr >> IDX_SH) & ~DVA_W'(3);
        ea_o     = (PA_W'(base_i) << BASE_SH) + PA_W'(idx_off);
    end
endmodule

// File: rtl/iopt_pte_check.sv
// Module: iopt_pte_check
// Decodes a fetched page table entry against the access type. Produces the
// physical address, permission code, fault flag and fault record contents.
// SWAP_BYTES selects a byte-lane reversal for a little-endian memory port.
// Purely combinational.
module iopt_pte_check #(
    parameter int unsigned DVA_W      = iopt_pkg::DVA_W,
    parameter int unsigned PA_W       = iopt_pkg::PA_W,
    parameter int unsigned PTE_W      = iopt_pkg::PTE_W,
    parameter int unsigned PAGE_SH    = iopt_pkg::PAGE_SH,
    parameter int unsigned PPN_LSB    = iopt_pkg::PTE_PPN_LSB,
    parameter int unsigned WR_BIT     = iopt_pkg::PTE_WR_BIT,
    parameter int unsigned VLD_BIT    = iopt_pkg::PTE_VLD_BIT,
    parameter bit          SWAP_BYTES = 1'b0
) (
    input  logic [PTE_W-1:0]  raw_i,
    input  logic [DVA_W-1:0]  dva_i,
    input  logic              is_write_i,
    output logic [PA_W-1:0]   pa_o,
    output iopt_pkg::perm_e   perm_o,
    output logic              fault_o,
    output logic [31:0]       status_o,
    output logic [DVA_W-1:0]  fault_addr_o
);
    import iopt_pkg::*;

    localparam int unsigned NBYTES = PTE_W / 8;

    logic [PTE_W-1:0] pte;
    logic             pte_vld;
    logic             pte_wr;
    logic             unused_pte_bits;

    // Byte order of the entry word as presented by the memory port.
    if (SWAP_BYTES) begin : g_swap
        for (genvar b = 0; b < NBYTES; b++) begin : g_lane
            assign pte[8*b +: 8] = raw_i[8*(NBYTES-1-b) +: 8];
        end
    end else begin : g_direct
        assign pte = raw_i;
    end

    // Cacheable and write-as-zero bits carry no meaning for translation.
    assign unused_pte_bits = ^{pte[PPN_LSB-1:WR_BIT+1], pte[0]};

    // Valid/writable decode and result formation.
    always_comb begin
        pte_vld      = pte[VLD_BIT];
        pte_wr       = pte[WR_BIT];
        fault_o      = !pte_vld || (is_write_i && !pte_wr);
        pa_o         = fault_o ? '0 : PA_W'({pte[PTE_W-1:PPN_LSB], dva_i[PAGE_SH-1:0]});
        perm_o       = fault_o ? PERM_NONE : (pte_wr ? PERM_RW : PERM_RO);
        status_o     = FLT_STAT_BASE | (is_write_i ? 32'h0 : FLT_STAT_READ);
        fault_addr_o = {dva_i[DVA_W-1:PAGE_SH], {PAGE_SH{1'b0}}};
    end
endmodule

// File: rtl/iopt_ctrl.sv
// Module: iopt_ctrl
// Sequencer for one translation at a time: accept, issue the entry read, wait
// for the entry word. Assumes the memory returns exactly one beat per read and
// never returns a beat before its request has been accepted.
module iopt_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid_i,
    input  logic rd_ready_i,
    input  logic rsp_valid_i,
    output logic req_ready_o,
    output logic rd_valid_o,
    output logic load_o,
    output logic capture_o
);
    import iopt_pkg::*;

    xl_state_e state_q;
    xl_state_e state_d;

    // Handshake decode from the current state.
    always_comb begin
        req_ready_o = (state_q == ST_IDLE);
        rd_valid_o  = (state_q == ST_FETCH);
        load_o      = req_ready_o && req_valid_i;
        capture_o   = (state_q == ST_WAIT) && rsp_valid_i;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid_i) state_d = ST_FETCH;
            ST_FETCH: if (rd_ready_i)  state_d = ST_WAIT;
            ST_WAIT:  if (rsp_valid_i) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/iopt_xlate_top.sv
// Module: iopt_xlate_top
// Single-level I/O page table translation engine. Latches the request and the
// configuration at acceptance, fetches one entry, and registers the decoded
// result into a one-cycle response pulse and, on a fault, a fault record.
// Assumes the register file applies any masking to cfg_base.
module iopt_xlate_top #(
    parameter int unsigned DVA_W      = iopt_pkg::DVA_W,
    parameter int unsigned PA_W       = iopt_pkg::PA_W,
    parameter int unsigned RANGE_W    = iopt_pkg::RANGE_W,
    parameter int unsigned PTE_W      = iopt_pkg::PTE_W,
    parameter bit          SWAP_BYTES = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DVA_W-1:0]   cfg_base,
    input  logic [RANGE_W-1:0] cfg_range,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [DVA_W-1:0]   req_addr,
    input  logic               req_write,
    output logic               pte_rd_valid,
    input  logic               pte_rd_ready,
    output logic [PA_W-1:0]    pte_rd_addr,
    input  logic               pte_rsp_valid,
    input  logic [PTE_W-1:0]   pte_rsp_data,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_pa,
    output logic [1:0]         rsp_perm,
    output logic               rsp_fault,
    output logic               flt_wr,
    output logic [31:0]        flt_status,
    output logic [DVA_W-1:0]   flt_addr,
    output logic               irq_raise
);
    import iopt_pkg::*;

    logic             load;
    logic             capture;
    logic [PA_W-1:0]  ea_next;
    logic [PA_W-1:0]  ea_q;
    logic [DVA_W-1:0] dva_q;
    logic             wr_q;
    logic [PA_W-1:0]  dec_pa;
    perm_e            dec_perm;
    logic             dec_fault;
    logic [31:0]      dec_status;
    logic [DVA_W-1:0] dec_faddr;

    iopt_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .rd_ready_i  (pte_rd_ready),
        .rsp_valid_i (pte_rsp_valid),
        .req_ready_o (req_ready),
        .rd_valid_o  (pte_rd_valid),
        .load_o      (load),
        .capture_o   (capture)
    );

    iopt_addr_gen #(
        .DVA_W   (DVA_W),
        .PA_W    (PA_W),
        .RANGE_W (RANGE_W)
    ) u_addr (
        .base_i  (cfg_base),
        .range_i (cfg_range),
        .dva_i   (req_addr),
        .ea_o    (ea_next)
    );

    iopt_pte_check #(
        .DVA_W      (DVA_W),
        .PA_W       (PA_W),
        .PTE_W      (PTE_W),
        .SWAP_BYTES (SWAP_BYTES)
    ) u_check (
        .raw_i        (pte_rsp_data),
        .dva_i        (dva_q),
        .is_write_i   (wr_q),
        .pa_o         (dec_pa),
        .perm_o       (dec_perm),
        .fault_o      (dec_fault),
        .status_o     (dec_status),
        .fault_addr_o (dec_faddr)
    );

    assign pte_rd_addr = ea_q;

    // Latch request fields and the entry address at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dva_q <= '0;
            wr_q  <= 1'b0;
            ea_q  <= '0;
        end else if (load) begin
            dva_q <= req_addr;
            wr_q  <= req_write;
            ea_q  <= ea_next;
        end
    end

    // One-cycle result and fault strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            flt_wr    <= 1'b0;
            irq_raise <= 1'b0;
        end else begin
            rsp_valid <= capture;
            rsp_fault <= capture && dec_fault;
            flt_wr    <= capture && dec_fault;
            irq_raise <= capture && dec_fault;
        end
    end

    // Result payload, updated on each captured entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_pa   <= '0;
            rsp_perm <= PERM_NONE;
        end else if (capture) begin
            rsp_pa   <= dec_pa;
            rsp_perm <= dec_perm;
        end
    end

    // Fault record payload, updated only on a faulting capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_status <= '0;
            flt_addr   <= '0;
        end else if (capture && dec_fault) begin
            flt_status <= dec_status;
            flt_addr   <= dec_faddr;
        end
    end
endmodule

// File: rtl/iopt_xlate_chk.sv
// Module: iopt_xlate_chk
// Protocol and result-format checker for iopt_xlate_top, bound to every instance.
module iopt_xlate_chk #(
    parameter int unsigned DVA_W = iopt_pkg::DVA_W,
    parameter int unsigned PA_W  = iopt_pkg::PA_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             pte_rd_valid,
    input logic             pte_rd_ready,
    input logic [PA_W-1:0]  pte_rd_addr,
    input logic             pte_rsp_valid,
    input logic             rsp_valid,
    input logic [1:0]       rsp_perm,
    input logic             rsp_fault,
    input logic             flt_wr,
    input logic [31:0]      flt_status,
    input logic [DVA_W-1:0] flt_addr,
    input logic             irq_raise
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !pte_rd_valid && !rsp_valid && !rsp_fault && !flt_wr && !irq_raise));

    // R9
    single_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && pte_rd_valid));

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pte_rd_valid && !pte_rd_ready) |=> (pte_rd_valid && $stable(pte_rd_addr)));

    // R12
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(pte_rsp_valid));

    // R12
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8
    fault_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_wr |-> (rsp_valid && rsp_fault && irq_raise));

    // R8
    fault_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault || irq_raise) |-> flt_wr);

    // R7
    fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_wr |-> (((flt_status & ~32'h0004_0000) == 32'hE082_0000) && (flt_addr[11:0] == 12'h000)));

    // R6
    perm_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault ? (rsp_perm == 2'b00) : rsp_perm[0]));
endmodule

bind iopt_xlate_top iopt_xlate_chk #(.DVA_W(DVA_W), .PA_W(PA_W)) u_xlate_chk (.*);

// File: tb/iopt_xlate_top_tb_top.sv
// Bench: behavioural cycle model of the translation engine with a memory model
// that stalls requests and varies response latency; compares every clock.
module iopt_xlate_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cfg_base;
    logic [2:0]  cfg_range;
    logic        req_valid, req_ready, req_write;
    logic [31:0] req_addr;
    logic        pte_rd_valid, pte_rd_ready;
    logic [35:0] pte_rd_addr;
    logic        pte_rsp_valid;
    logic [31:0] pte_rsp_data;
    logic        rsp_valid, rsp_fault, flt_wr, irq_raise;
    logic [35:0] rsp_pa;
    logic [1:0]  rsp_perm;
    logic [31:0] flt_status, flt_addr;

    always #2 clk = ~clk;

    iopt_xlate_top dut_i (.*);

    typedef struct {
        logic [31:0] addr;
        bit          wr;
        logic [31:0] base;
        logic [2:0]  rng;
        string       tag;
    } req_t;

    req_t        rq[$];
    logic [31:0] pt_mem [logic [35:0]];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    function automatic logic [35:0] ref_ea(logic [31:0] base, logic [2:0] rng, logic [31:0] a);
        longint unsigned win, rel, ea;
        win = 64'd1 << (24 + rng);
        rel = longint'(a) % win;
        ea  = longint'(base) * 16 + ((rel / 1024) / 4) * 4;
        return ea[35:0];
    endfunction

    function automatic logic [31:0] ref_pte(logic [35:0] ea);
        if (pt_mem.exists(ea)) return pt_mem[ea];
        return (ea[31:0] * 32'h9E37_79B9) ^ 32'h1357_9BDF;
    endfunction

    task automatic chk(bit ok, string tag, string what, longint unsigned act, longint unsigned exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(logic [31:0] a, bit w, logic [31:0] b, logic [2:0] r, bit put, logic [31:0] pte, string tag);
        req_t it;
        it.addr = a; it.wr = w; it.base = b; it.rng = r; it.tag = tag;
        if (put) pt_mem[ref_ea(b, r, a)] = pte;
        rq.push_back(it);
    endtask

    initial begin
        int          ms;
        int          cnt;
        req_t        cur;
        logic [35:0] cur_ea;
        bit          e_rv, e_fault;
        logic [35:0] e_pa;
        logic [1:0]  e_perm;
        logic [31:0] e_stat, e_faddr, pte;

        rst_n = 1'b0; cfg_base = '0; cfg_range = '0;
        req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
        pte_rd_ready = 1'b0; pte_rsp_valid = 1'b0; pte_rsp_data = '0;
        ms = 0; cnt = 0; e_rv = 0; e_fault = 0; e_pa = '0; e_perm = '0;
        e_stat = '0; e_faddr = '0; cur_ea = '0;

        // R5: read of valid read-only entry succeeds
        push(32'h0000_1234, 0, 32'h0001_0000, 3'd0, 1, 32'h0ABC_DE02, "R5");
        // R6: write to writable entry gives read-write
        push(32'h0000_2ABC, 1, 32'h0001_0000, 3'd0, 1, 32'h1234_5606, "R6");
        // R5: write to read-only entry faults
        push(32'h0000_3000, 1, 32'h0001_0000, 3'd0, 1, 32'h0000_0102, "R5");
        // R4: invalid entry on read, smallest window clears high address bits
        push(32'hFFAB_C123, 0, 32'h07FF_FC00, 3'd0, 1, 32'hFFFF_FF00, "R4");
        // R4: invalid entry on write, largest window
        push(32'h8123_4567, 1, 32'h0400_0000, 3'd7, 1, 32'h0000_0000, "R4");
        // R11: cacheable and write-as-zero bits set
        push(32'h00FF_FFFF, 0, 32'h0000_2000, 3'd1, 1, 32'hABCD_EF87, "R11");
        // R11: same page number with those bits clear
        push(32'h00FF_FFFF, 0, 32'h0000_4000, 3'd1, 1, 32'hABCD_EF06, "R11");
        // R3: varied addresses, windows and entries
        for (int i = 0; i < 300; i++) begin
            push($urandom, 1'($urandom), $urandom & 32'h07FF_FC00, 3'($urandom), 0, 32'h0, "R3");
        end

        repeat (4) @(negedge clk);
        // R1: state while reset is held
        chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        chk(pte_rd_valid == 1'b0, "R1", "pte_rd_valid", pte_rd_valid, 0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
        chk(flt_wr == 1'b0 && irq_raise == 1'b0, "R1", "flt_wr|irq", flt_wr | irq_raise, 0);
        rst_n = 1'b1;

        forever begin
            @(negedge clk);
            // Compare outputs against the model state reached at the last edge.
            chk(req_ready == (ms == 0), "R9", "req_ready", req_ready, ms == 0);
            chk(pte_rd_valid == (ms == 1), "R9", "pte_rd_valid", pte_rd_valid, ms == 1);
            if (ms == 1) chk(pte_rd_addr == cur_ea, "R2 R10", "pte_rd_addr", pte_rd_addr, cur_ea);
            chk(rsp_valid == e_rv, "R12", "rsp_valid", rsp_valid, e_rv);
            if (e_rv) begin
                chk(rsp_fault == e_fault, e_fault ? cur.tag : "R5", "rsp_fault", rsp_fault, e_fault);
                chk(rsp_pa == e_pa, cur.tag == "R11" ? "R11" : "R3", "rsp_pa", rsp_pa, e_pa);
                chk(rsp_perm == e_perm, "R6", "rsp_perm", rsp_perm, e_perm);
                chk(flt_wr == e_fault, "R8", "flt_wr", flt_wr, e_fault);
                chk(irq_raise == e_fault, "R7", "irq_raise", irq_raise, e_fault);
                if (e_fault) begin
                    chk(flt_status == e_stat, "R7", "flt_status", flt_status, e_stat);
                    chk(flt_addr == e_faddr, "R7", "flt_addr", flt_addr, e_faddr);
                end
            end else begin
                chk(flt_wr == 1'b0 && rsp_fault == 1'b0 && irq_raise == 1'b0, "R8",
                    "flt_wr|rsp_fault|irq", {flt_wr, rsp_fault, irq_raise}, 0);
            end

            if (rq.size() == 0 && ms == 0) break;

            // Drive the next cycle and advance the model.
            e_rv = 0;
            req_valid = 1'b0; pte_rd_ready = 1'b0; pte_rsp_valid = 1'b0;
            pte_rsp_data = $urandom;
            case (ms)
                0: begin
                    if (rq.size() != 0 && ($urandom % 4) != 0) begin
                        cur = rq.pop_front();
                        req_valid = 1'b1; req_addr = cur.addr; req_write = cur.wr;
                        cfg_base = cur.base; cfg_range = cur.rng;
                        cur_ea = ref_ea(cur.base, cur.rng, cur.addr);
                        ms = 1;
                    end else begin
                        req_addr = $urandom; req_write = 1'($urandom);
                        cfg_base = $urandom; cfg_range = 3'($urandom);
                    end
                end
                1: begin
                    // R10: configuration churns while the translation is in flight
                    cfg_base = $urandom; cfg_range = 3'($urandom); req_addr = $urandom;
                    if (($urandom % 3) != 0) begin
                        pte_rd_ready = 1'b1;
                        cnt = $urandom % 4;
                        ms = 2;
                    end
                end
                default: begin
                    cfg_base = $urandom; cfg_range = 3'($urandom);
                    if (cnt == 0) begin
                        pte = ref_pte(cur_ea);
                        pte_rsp_valid = 1'b1; pte_rsp_data = pte;
                        e_fault = !pte[1] || (cur.wr && !pte[2]);
                        e_pa    = e_fault ? 36'h0 : {pte[31:8], cur.addr[11:0]};
                        e_perm  = e_fault ? 2'b00 : (pte[2] ? 2'b11 : 2'b01);
                        e_stat  = cur.wr ? 32'hE082_0000 : 32'hE086_0000;
                        e_faddr = {cur.addr[31:12], 12'h000};
                        e_rv = 1;
                        ms = 0;
                    end else begin
                        cnt--;
                    end
                end
            endcase
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R12 watchdog act=%0h exp=%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule